// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It runs on the output clock of an external dual-modulus prescaler, which divides by either P or P+1, and it steers that prescaler through a modulus-control line. In each output period a main counter counts B prescaler pulses. During the first A of them, a swallow counter holds the prescaler at P+1. The prescaler input therefore sees one output pulse for every N = B·P + A of its own cycles.

Software or a neighbouring controller presents a swallow value A (6 bits), a main value B (11 bits) and a base select with a one-cycle load strobe. The divider checks the set. A legal set is held until the current output period ends and is then used for the next period, so no period is ever cut short. An illegal set raises an error pulse and is thrown away. The base select is passed on to the prescaler as a registered line, and that line also changes only at period boundaries. The block never divides by a base itself.

Top module: `swallow_divider`

## Requirements
- R1: Between consecutive output pulses the prescaler input sees exactly B·P + A cycles. This counts P+1 input cycles for every prescaler-output cycle with `mod_ctl` high and P for every other cycle, and it holds for B from 3 to 2047 and A from 0 to 63 with A ≤ B.
- R2: In each output period `mod_ctl` (1 = divide by P+1) is high for the first A prescaler-output cycles and low for the remaining B−A cycles. With A = 0 it stays low for the whole period, and with A = B it stays high for the whole period.
- R3: `div_out` is high for exactly one prescaler-output cycle per period, namely the B-th and last cycle, and the counters restart on the following clock edge.
- R4: `pre_big` drives the prescaler base. A value of 0 selects the small base (32) and a value of 1 selects the large base (64). It follows the accepted `cfg_psel` and changes only where a new output period starts.
- R5: A load is accepted when B ≥ 3 and A ≤ B. The period in progress completes with its old values. The accepted set governs every period that begins after the load edge, including the very next one when the load coincides with the terminal cycle. When several loads are accepted within one period, the last one wins.
- R6: A load with B < 3 or A > B makes `load_err` high for exactly the one cycle after the load edge. The load is otherwise ignored: the running values and any earlier accepted pending set stay in effect.
- R7: Synchronous reset clears `div_out`, `mod_ctl`, `load_err` and `pre_big` and installs A = 0, B = 16 and the small base. The first output period begins with the first clock edge after reset is released, so its pulse appears in the 16th cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock, one edge per prescaler pulse |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Strobe that presents a new A/B/base set |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 11 | Main count B |
| cfg_psel | input | 1 | Base select: 0 small base, 1 large base |
| mod_ctl | output | 1 | Modulus control to prescaler, 1 = P+1 |
| div_out | output | 1 | Divided output pulse, one cycle per period |
| pre_big | output | 1 | Registered base select to prescaler |
| load_err | output | 1 | One-cycle flag for a rejected load |

## Verification
Every output is registered, so a value that depends on an edge appears one clock later. The bench samples each output on the falling edge that follows the rising edge producing it. `load_err` is therefore checked on the sample right after the load, and a new A/B/base set is first seen on the first sample after the terminal sample of the period in progress. The bench keeps a model of the running set and the pending set. It rolls the running set over exactly when it observes the terminal sample. It then compares `mod_ctl`, `div_out` and `pre_big` sample by sample, and it compares the accumulated prescaler-input cycle count against B·P + A at every pulse.

// File: rtl/sw_div_pkg.sv
package sw_div_pkg;
  localparam int A_W = 6;
  localparam int B_W = 11;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           psel;
  } div_cfg_t;
endpackage

// File: rtl/sw_div_cfg.sv
module sw_div_cfg
  import sw_div_pkg::*;
#(
  parameter int B_MIN    = 3,
  parameter int DEF_A    = 0,
  parameter int DEF_B    = 16,
  parameter int DEF_PSEL = 0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  div_cfg_t in_cfg,
  input  logic     wrap,
  output div_cfg_t act,
  output div_cfg_t nxt,
  output logic     err
);
  localparam logic [B_W-1:0] BMIN_V = B_W'(B_MIN);
  localparam div_cfg_t DEF_CFG = '{a: A_W'(DEF_A), b: B_W'(DEF_B), psel: 1'(DEF_PSEL)};

  div_cfg_t pend;
  logic     pend_v;
  logic     ok;

  // legality of the presented set
  assign ok = load && (in_cfg.b >= BMIN_V) &&
              ({{(B_W-A_W){1'b0}}, in_cfg.a} <= in_cfg.b);

  // set that the next period will use
  always_comb begin
    if (ok)          nxt = in_cfg;
    else if (pend_v) nxt = pend;
    else             nxt = act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= DEF_CFG;
      pend   <= DEF_CFG;
      pend_v <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= load && !ok;
      if (wrap) begin
        act    <= nxt;
        pend_v <= 1'b0;
      end else if (ok) begin
        pend   <= in_cfg;
        pend_v <= 1'b1;
      end
    end
  end

  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (act.b >= BMIN_V) && ({{(B_W-A_W){1'b0}}, act.a} <= act.b)); // R5
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act)); // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(load)); // R6
endmodule

// File: rtl/sw_div_count.sv
module sw_div_count
  import sw_div_pkg::*;
#(
  parameter int DEF_A = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] act_a,
  input  logic [B_W-1:0] act_b,
  input  logic [A_W-1:0] nxt_a,
  input  logic [B_W-1:0] nxt_b,
  output logic           mod_q,
  output logic           div_q
);
  logic [B_W-1:0] k;
  logic [B_W-1:0] k_nxt;
  logic [A_W-1:0] a_use;
  logic [B_W-1:0] b_use;

  // div_q marks the last cycle of the period: restart there
  always_comb begin
    if (div_q) begin
      k_nxt = '0;
      a_use = nxt_a;
      b_use = nxt_b;
    end else begin
      k_nxt = k + 1'b1;
      a_use = act_a;
      b_use = act_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k     <= '0;
      mod_q <= (DEF_A != 0);
      div_q <= 1'b0;
    end else begin
      k     <= k_nxt;
      mod_q <= (k_nxt < {{(B_W-A_W){1'b0}}, a_use});
      div_q <= (k_nxt == b_use - 1'b1);
    end
  end

  AST_K_BOUND: assert property (@(posedge clk) disable iff (rst)
    k < act_b); // R3
  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    div_q |=> !div_q); // R3
  AST_MOD_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_q) |-> $past(div_q)); // R2
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import sw_div_pkg::*;
#(
  parameter int B_MIN    = 3,
  parameter int DEF_A    = 0,
  parameter int DEF_B    = 16,
  parameter int DEF_PSEL = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [5:0] cfg_a,
  input  logic [10:0] cfg_b,
  input  logic       cfg_psel,
  output logic       mod_ctl,
  output logic       div_out,
  output logic       pre_big,
  output logic       load_err
);
  div_cfg_t in_cfg, act, nxt;
  logic     wrap;

  assign in_cfg = '{a: cfg_a, b: cfg_b, psel: cfg_psel};

  sw_div_cfg #(
    .B_MIN(B_MIN), .DEF_A(DEF_A), .DEF_B(DEF_B), .DEF_PSEL(DEF_PSEL)
  ) cfg_i (
    .clk(clk), .rst(rst), .load(load), .in_cfg(in_cfg),
    .wrap(wrap), .act(act), .nxt(nxt), .err(load_err)
  );

  sw_div_count #(.DEF_A(DEF_A)) cnt_i (
    .clk(clk), .rst(rst),
    .act_a(act.a), .act_b(act.b),
    .nxt_a(nxt.a), .nxt_b(nxt.b),
    .mod_q(mod_ctl), .div_q(wrap)
  );

  assign div_out = wrap;
  assign pre_big = act.psel;

  AST_BASE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(pre_big)); // R4
endmodule

// File: tb/swallow_divider_tb_top.sv
module swallow_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_LO = 32;
  localparam int P_HI = 64;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [5:0] cfg_a = '0;
  logic [10:0] cfg_b = '0;
  logic cfg_psel = 1'b0;
  logic mod_ctl, div_out, pre_big, load_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider dut_i (
    .clk(clk), .rst(rst), .load(load), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .cfg_psel(cfg_psel), .mod_ctl(mod_ctl), .div_out(div_out),
    .pre_big(pre_big), .load_err(load_err)
  );

  int compared = 0, mismatched = 0;
  int cur_a = 0, cur_b = 16, cur_ps = 0;
  int pend_a = 0, pend_b = 0, pend_ps = 0;
  bit pend_v = 0;
  int idx = 0, sum = 0, cycles_done = 0;
  bit arm = 0, exp_err = 0;
  bit d_load = 0, d_rst = 1;
  int d_a = 0, d_b = 0, d_ps = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic step();
    bit rolled;
    int p;
    rolled = 0;
    @(negedge clk);
    if (arm) begin
      idx++;
      p = (pre_big === 1'b1) ? P_HI : P_LO;
      sum += (mod_ctl === 1'b1) ? p + 1 : p;
      chk(int'(pre_big) == cur_ps, "R4", "pre_big", int'(pre_big), cur_ps);
      chk(int'(mod_ctl) == int'(idx <= cur_a), "R2", "mod_ctl", int'(mod_ctl), int'(idx <= cur_a));
      chk(int'(div_out) == int'(idx == cur_b), "R3", "div_out", int'(div_out), int'(idx == cur_b));
      chk(int'(load_err) == int'(exp_err), "R6", "load_err", int'(load_err), int'(exp_err));
      if (div_out === 1'b1 || idx >= cur_b) begin
        chk(sum == cur_b * (cur_ps != 0 ? P_HI : P_LO) + cur_a, "R1", "input cycles per pulse",
            sum, cur_b * (cur_ps != 0 ? P_HI : P_LO) + cur_a);
        idx = 0; sum = 0; cycles_done++; rolled = 1;
        if (pend_v) begin
          cur_a = pend_a; cur_b = pend_b; cur_ps = pend_ps; pend_v = 0;
        end
      end
    end
    exp_err = 0;
    if (d_load) begin
      if (d_b >= 3 && d_a <= d_b) begin
        if (rolled) begin cur_a = d_a; cur_b = d_b; cur_ps = d_ps; end
        else begin pend_a = d_a; pend_b = d_b; pend_ps = d_ps; pend_v = 1; end
      end else exp_err = 1;
    end
    load = d_load;
    cfg_a = 6'(d_a);
    cfg_b = 11'(d_b);
    cfg_psel = 1'(d_ps);
    rst = d_rst;
    d_load = 0;
  endtask

  task automatic apply(input int a, input int b, input int ps);
    d_load = 1; d_a = a; d_b = b; d_ps = ps;
    step();
  endtask

  task automatic wait_cycles(input int n);
    int tgt;
    tgt = cycles_done + n;
    while (cycles_done < tgt) step();
  endtask

  initial begin
    repeat (4) step();
    // R7: reset values
    chk(div_out == 1'b0, "R7", "div_out in reset", int'(div_out), 0);
    chk(mod_ctl == 1'b0, "R7", "mod_ctl in reset", int'(mod_ctl), 0);
    chk(load_err == 1'b0, "R7", "load_err in reset", int'(load_err), 0);
    chk(pre_big == 1'b0, "R7", "pre_big in reset", int'(pre_big), 0);
    arm = 1; d_rst = 0;
    step();
    repeat (14) step();
    chk(cycles_done == 0, "R7", "no pulse before cycle 16", cycles_done, 0);
    step();
    chk(cycles_done == 1, "R7", "pulse in cycle 16", cycles_done, 1);

    // R1 R2 R3: sweep of small settings
    for (int b = 3; b <= 18; b++)
      for (int a = 0; a <= b; a++) begin
        apply(a, b, (a + b) % 2);
        wait_cycles(2);
      end

    // R1: extremes of the ranges
    apply(63, 2047, 1); wait_cycles(2);
    apply(0, 2047, 0);  wait_cycles(2);
    apply(63, 63, 1);   wait_cycles(2);
    apply(0, 3, 0);     wait_cycles(2);

    // R6: rejected loads leave the running set alone
    apply(5, 20, 0); wait_cycles(2);
    apply(0, 2, 1);  wait_cycles(1);
    apply(30, 29, 0); wait_cycles(1);
    apply(0, 0, 1);  apply(1, 1, 0); wait_cycles(2);

    // R6: rejected load keeps an earlier accepted pending set
    apply(7, 40, 1); step(); apply(0, 1, 0); wait_cycles(2);

    // R5: two accepted loads in one period, last wins
    apply(3, 50, 0); apply(9, 12, 1); wait_cycles(2);

    // R5: load on the terminal cycle applies to the very next period
    while (idx != cur_b - 1) step();
    apply(4, 6, 0);
    chk(cur_b == 6, "R5", "terminal-cycle load taken at once", cur_b, 6);
    wait_cycles(1);

    // R5: mid-period load does not truncate the running period
    apply(2, 25, 1); repeat (5) step(); apply(1, 9, 0); wait_cycles(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_LIMIT, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule